// File: doc/BRIEF.md
# Accumulator Barrel Shifter

This block is the variable shifter of a DSP bit-manipulation datapath. It takes a 36-bit accumulator value (32 data bits with 4 guard bits above them) and shifts it by a signed count. The count comes from the upper half of a 32-bit control word. A 2-bit kind code picks an arithmetic or logical shift and a nominal direction. When the count is negative, the direction flips but the shift stays arithmetic or logical. The block returns the shifted value and eight condition flags, all computed from that value.

The block is a two-stage pipeline. The first stage registers the decoded count, the direction and the operand (with the guard bits cleared where required). The second stage registers the shifted value and its flags. A new operation can be presented on every cycle. Instruction decode and register-file access belong to the surrounding datapath.

Top module: `acc_barrel_shifter`

## Requirements
- R1: An operation presented before clock edge k appears on `result_o`/`flags_o` after edge k+1 (two-cycle latency), one operation per cycle. While `rst_ni` is low, both outputs are zero.
- R2: The shift count is the two's-complement value in `ctrl_i[31:16]`. Bits 15..0 of `ctrl_i` have no effect on either output.
- R3: `kind_i` encoding: 2'b00 arithmetic right, 2'b01 logical right, 2'b10 arithmetic left, 2'b11 logical left.
- R4: A negative count shifts in the opposite direction by its magnitude and keeps the arithmetic or logical kind. A count of -32768 gives a shift of 32768.
- R5: An arithmetic right shift fills with copies of operand bit 35, and a logical right shift fills with zeros. A right shift of 36 or more gives 36 copies of the fill bit.
- R6: When `kind_i` is 2'b01, operand bits 35..32 are cleared before shifting, whatever the sign of the count. Other kinds use the operand unchanged.
- R7: Left shifts fill with zeros. A left shift of 36 or more gives zero.
- R8: Lost flag (`flags_o[2]`) for a left shift by n. For an arithmetic left shift it is set if any of the top n+1 operand bits differs from bit 35. For a logical left shift it is set if any of the top n operand bits is one. When n is 36 or more, it is set whenever the operand is non-zero.
- R9: Lost flag for a right shift: set exactly when the shift magnitude is greater than 35.
- R10: `flags_o[0]` is result bit 35. `flags_o[1]` is set when the whole 36-bit result is zero. `flags_o[3]` is set when result bits 35..31 are not all equal.
- R11: `flags_o[4]` is set when result bits 31..0 hold an odd number of ones, and `flags_o[5]` is its complement. `flags_o[6]` is set when the result is all ones, and `flags_o[7]` is its complement.
- R12: A count of zero returns the operand unchanged (after the guard clearing of R6) and clears the lost flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| operand_i | input | 36 | Accumulator value to shift |
| ctrl_i | input | 32 | Control word; bits 31..16 hold the signed count |
| kind_i | input | 2 | Shift kind code |
| result_o | output | 36 | Shifted value |
| flags_o | output | 8 | Condition flags, bit positions as in R10, R8/R9 and R11 |

## Verification
The assertions check, on every cycle, the behaviour of the second stage given the first stage's registered state:
- guard bits are zero after a logical right shift;
- right-shift saturation and the lost flag for right shifts;
- a zero result for left shifts of 36 or more;
- a zero count passes the operand through with the lost flag clear.

Only the bench's scenarios can show the rest:
- the meaning of the kind codes;
- direction reversal for negative counts, including -32768;
- that the low control bits are ignored;
- the left-shift lost-bit rules on chosen patterns;
- the parity and all-ones flags;
- that back-to-back operations arrive in order at two-cycle latency.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  typedef enum logic [1:0] {
    SH_ASR = 2'b00,
    SH_LSR = 2'b01,
    SH_ASL = 2'b10,
    SH_LSL = 2'b11
  } shift_kind_e;

  localparam int unsigned FLAG_W    = 8;
  localparam int unsigned FL_NEG    = 0;
  localparam int unsigned FL_ZERO   = 1;
  localparam int unsigned FL_LOST   = 2;
  localparam int unsigned FL_OVF    = 3;
  localparam int unsigned FL_ODD    = 4;
  localparam int unsigned FL_EVEN   = 5;
  localparam int unsigned FL_MONE   = 6;
  localparam int unsigned FL_NMONE  = 7;
endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  count_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              left_o,
  output logic              arith_o,
  output logic [AMT_W-1:0]  amt_o,
  output logic              sat_o
);
  localparam int unsigned GUARD_W = DATA_W - WORD_W;

  logic             neg;
  logic [CNT_W:0]   cnt_ext;
  logic [CNT_W:0]   mag;

  assign neg     = count_i[CNT_W-1];
  assign cnt_ext = {count_i[CNT_W-1], count_i};
  // 17-bit magnitude so that the most negative count stays exact
  assign mag     = neg ? (~cnt_ext + 1'b1) : cnt_ext;

  assign left_o  = kind_i[1] ^ neg;
  assign arith_o = ~kind_i[0];
  assign sat_o   = (mag >= (CNT_W+1)'(DATA_W));
  assign amt_o   = sat_o ? '0 : mag[AMT_W-1:0];

  assign operand_o = (kind_i == SH_LSR) ? {{GUARD_W{1'b0}}, operand_i[WORD_W-1:0]}
                                        : operand_i;
endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              left_i,
  input  logic              arith_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] result_o,
  output logic              lost_o
);
  logic              sign;
  logic              fill;
  logic [DATA_W-1:0] rstage [AMT_W+1];
  logic [DATA_W-1:0] lstage [AMT_W+1];

  assign sign      = operand_i[DATA_W-1];
  assign fill      = arith_i & sign;
  assign rstage[0] = operand_i;
  assign lstage[0] = operand_i;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int unsigned SH = 1 << i;
    if (SH < DATA_W) begin : g_shift
      assign rstage[i+1] = amt_i[i] ? {{SH{fill}}, rstage[i][DATA_W-1:SH]} : rstage[i];
      assign lstage[i+1] = amt_i[i] ? {lstage[i][DATA_W-1-SH:0], {SH{1'b0}}} : lstage[i];
    end else begin : g_flush
      assign rstage[i+1] = amt_i[i] ? {DATA_W{fill}} : rstage[i];
      assign lstage[i+1] = amt_i[i] ? '0 : lstage[i];
    end
  end

  // lost-bit detection for left shifts: masks of the top bits
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
  logic [AMT_W:0]    amt_p1;
  logic [DATA_W-1:0] top_n_mask;
  logic [DATA_W-1:0] top_n1_mask;
  logic              any_set;
  logic              lost_arith;
  logic              lost_logic;

  assign amt_p1      = {1'b0, amt_i} + 1'b1;
  assign top_n_mask  = ~(ONES >> amt_i);
  assign top_n1_mask = ~(ONES >> amt_p1);
  assign any_set     = |operand_i;
  assign lost_arith  = sat_i ? any_set : |((operand_i ^ {DATA_W{sign}}) & top_n1_mask);
  assign lost_logic  = sat_i ? any_set : |(operand_i & top_n_mask);

  always_comb begin
    if (left_i) begin
      result_o = sat_i ? '0 : lstage[AMT_W];
      lost_o   = arith_i ? lost_arith : lost_logic;
    end else begin
      result_o = sat_i ? {DATA_W{fill}} : rstage[AMT_W];
      lost_o   = sat_i;
    end
  end
endmodule

// File: rtl/acc_shift_flags.sv
module acc_shift_flags
  import acc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned WORD_W = 32
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              lost_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned TOP_W = DATA_W - WORD_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             odd;
  logic             mone;

  assign top_bits = result_i[DATA_W-1:WORD_W-1];
  assign odd      = ^result_i[WORD_W-1:0];
  assign mone     = &result_i;

  always_comb begin
    flags_o            = '0;
    flags_o[FL_NEG]    = result_i[DATA_W-1];
    flags_o[FL_ZERO]   = (result_i == '0);
    flags_o[FL_LOST]   = lost_i;
    flags_o[FL_OVF]    = ~((&top_bits) | ~(|top_bits));
    flags_o[FL_ODD]    = odd;
    flags_o[FL_EVEN]   = ~odd;
    flags_o[FL_MONE]   = mone;
    flags_o[FL_NMONE]  = ~mone;
  end
endmodule

// File: rtl/acc_barrel_shifter.sv
module acc_barrel_shifter
  import acc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [1:0]        kind_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned AMT_W = $clog2(DATA_W);
  localparam int unsigned CNT_LO = CTRL_W - CNT_W;

  logic [CNT_LO-1:0] unused_ctrl;
  assign unused_ctrl = ctrl_i[CNT_LO-1:0];

  // stage 1: decode
  logic [DATA_W-1:0] d_operand;
  logic              d_left, d_arith, d_sat;
  logic [AMT_W-1:0]  d_amt;

  acc_shift_decode #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .AMT_W(AMT_W)
  ) u_decode (
    .operand_i (operand_i),
    .count_i   (ctrl_i[CTRL_W-1:CNT_LO]),
    .kind_i    (shift_kind_e'(kind_i)),
    .operand_o (d_operand),
    .left_o    (d_left),
    .arith_o   (d_arith),
    .amt_o     (d_amt),
    .sat_o     (d_sat)
  );

  logic [DATA_W-1:0] s1_operand;
  logic              s1_left, s1_arith, s1_sat;
  logic [AMT_W-1:0]  s1_amt;
  logic [1:0]        s1_kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_operand <= '0;
      s1_left    <= 1'b0;
      s1_arith   <= 1'b0;
      s1_sat     <= 1'b0;
      s1_amt     <= '0;
      s1_kind    <= '0;
    end else begin
      s1_operand <= d_operand;
      s1_left    <= d_left;
      s1_arith   <= d_arith;
      s1_sat     <= d_sat;
      s1_amt     <= d_amt;
      s1_kind    <= kind_i;
    end
  end

  // stage 2: shift and flags
  logic [DATA_W-1:0] c_result;
  logic              c_lost;
  logic [FLAG_W-1:0] c_flags;

  acc_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .operand_i (s1_operand),
    .left_i    (s1_left),
    .arith_i   (s1_arith),
    .amt_i     (s1_amt),
    .sat_i     (s1_sat),
    .result_o  (c_result),
    .lost_o    (c_lost)
  );

  acc_shift_flags #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_flags (
    .result_i (c_result),
    .lost_i   (c_lost),
    .flags_o  (c_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= c_result;
      flags_o  <= c_flags;
    end
  end

  assert_guard_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_kind == SH_LSR && !s1_left) |=> (result_o[DATA_W-1:WORD_W] == '0));

  assert_right_lost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_left |=> (flags_o[FL_LOST] == $past(s1_sat)));

  assert_left_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_left && s1_sat) |=> (result_o == '0));

  assert_right_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_left && s1_sat && s1_arith) |=>
      (result_o == {DATA_W{$past(s1_operand[DATA_W-1])}}));

  assert_zero_count_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_sat && s1_amt == '0) |=>
      (result_o == $past(s1_operand) && !flags_o[FL_LOST]));
endmodule

// File: tb/acc_barrel_shifter_test.sv
`timescale 1ns/1ps
module acc_barrel_shifter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [35:0] operand_i = '0;
  logic [31:0] ctrl_i = '0;
  logic [1:0]  kind_i = '0;
  logic [35:0] result_o;
  logic [7:0]  flags_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  acc_barrel_shifter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .operand_i(operand_i),
    .ctrl_i(ctrl_i), .kind_i(kind_i), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic logic [43:0] model(input logic [35:0] op, input logic [31:0] ctrl,
                                        input logic [1:0] kind);
    int cnt, mag;
    logic left, arith, lost, odd;
    logic [35:0] x, r;
    logic signed [35:0] xs;
    logic [7:0] f;
    cnt   = int'($signed(ctrl[31:16]));
    mag   = (cnt < 0) ? -cnt : cnt;
    left  = kind[1] ^ (cnt < 0);
    arith = !kind[0];
    x     = (kind == 2'b01) ? {4'b0, op[31:0]} : op;
    xs    = x;
    lost  = 1'b0;
    if (!left) begin
      if (mag >= 36) r = arith ? {36{x[35]}} : '0;
      else r = arith ? 36'(xs >>> mag) : (x >> mag);
      lost = (mag > 35);
    end else begin
      r = (mag >= 36) ? '0 : (x << mag);
      for (int j = 0; j < 36; j++) begin
        if (arith && (j >= 35 - mag) && (x[j] != x[35])) lost = 1'b1;
        if (!arith && (j >= 36 - mag) && x[j]) lost = 1'b1;
      end
      if (arith && mag >= 36 && x[35]) lost = 1'b1;
    end
    odd  = ^r[31:0];
    f[0] = r[35];
    f[1] = (r == '0);
    f[2] = lost;
    f[3] = !((r[35:31] == 5'h1f) || (r[35:31] == 5'h00));
    f[4] = odd;
    f[5] = !odd;
    f[6] = (r == {36{1'b1}});
    f[7] = !f[6];
    return {f, r};
  endfunction

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run(input logic [35:0] op, input logic [31:0] ctrl, input logic [1:0] kind,
                     input string rreq, input string freq);
    logic [43:0] e;
    @(negedge clk_i);
    operand_i = op; ctrl_i = ctrl; kind_i = kind;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    e = model(op, ctrl, kind);
    check(rreq, result_o, e[35:0]);
    check(freq, {28'b0, flags_o}, {28'b0, e[43:36]});
  endtask

  function automatic logic [31:0] cw(input int c);
    return {16'(c), 16'h0000};
  endfunction

  task automatic t_reset;
    rst_ni = 1'b0;
    operand_i = 36'h9_1234_5678; ctrl_i = cw(3); kind_i = 2'b10;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset result", result_o, '0);
    check("R1 reset flags", {28'b0, flags_o}, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_right;
    run(36'h8_0000_00F0, cw(4),  2'b00, "R5 asr", "R10 asr");
    run(36'h7_FFFF_FFFF, cw(35), 2'b00, "R5 asr35", "R9 asr35");
    run(36'hF_1234_5678, cw(36), 2'b00, "R5 asr36", "R9 asr36");
    run(36'h8_8000_0001, cw(100),2'b00, "R5 asr100", "R9 asr100");
    run(36'h0_0000_0003, cw(1),  2'b00, "R3 asr1", "R11 asr1");
  endtask

  task automatic t_logical_right;
    run(36'hF_8000_0000, cw(4),  2'b01, "R6 lsr4", "R10 lsr4");
    run(36'hA_FFFF_FFFF, cw(0),  2'b01, "R6 lsr0", "R12 lsr0");
    run(36'hF_FFFF_FFFF, cw(40), 2'b01, "R5 lsr40", "R9 lsr40");
    run(36'h5_0000_0001, cw(-3), 2'b01, "R6 lsr neg", "R8 lsr neg");
  endtask

  task automatic t_left;
    run(36'h0_0000_1234, cw(8),  2'b10, "R7 asl", "R8 asl ok");
    run(36'h0_4000_0000, cw(1),  2'b10, "R7 asl1", "R8 asl ovf32");
    run(36'h4_0000_0000, cw(1),  2'b10, "R7 asl sign", "R8 asl signchg");
    run(36'hF_FFFF_FFF0, cw(3),  2'b10, "R7 asl neg", "R8 asl neg ok");
    run(36'hF_FFFF_FFFF, cw(36), 2'b10, "R7 asl36", "R8 asl36 ones");
    run(36'h0_0000_0000, cw(50), 2'b10, "R7 asl50", "R8 asl50 zero");
    run(36'h8_0000_0001, cw(1),  2'b11, "R3 lsl1", "R8 lsl lost");
    run(36'h4_0000_0001, cw(1),  2'b11, "R3 lsl keep", "R8 lsl ok");
    run(36'h0_0000_0001, cw(35), 2'b11, "R7 lsl35", "R8 lsl35");
  endtask

  task automatic t_negative;
    logic [35:0] a, b;
    run(36'h8_0000_0100, cw(-4), 2'b00, "R4 asr neg", "R8 asr neg");
    run(36'h8_0000_0100, cw(-4), 2'b10, "R4 asl neg", "R9 asl neg");
    run(36'hC_0000_0000, cw(-32768), 2'b10, "R4 min count", "R9 min count");
    run(36'h0_0000_0001, cw(-1), 2'b11, "R4 lsl neg", "R9 lsl neg");
    run(36'h8_0000_0100, cw(-4), 2'b00, "R4 asr neg again", "R8 asr neg again");
    a = result_o;
    run(36'h8_0000_0100, cw(4), 2'b10, "R4 asl pos", "R8 asl pos");
    b = result_o;
    check("R4 reversal equivalence", a, b);
  endtask

  task automatic t_ignored_bits;
    logic [35:0] a; logic [7:0] fa;
    run(36'h3_1357_9BDF, 32'h0005_0000, 2'b00, "R2 clean", "R2 clean flags");
    a = result_o; fa = flags_o;
    run(36'h3_1357_9BDF, 32'h0005_FFFF, 2'b00, "R2 dirty", "R2 dirty flags");
    check("R2 low bits ignored result", result_o, a);
    check("R2 low bits ignored flags", {28'b0, flags_o}, {28'b0, fa});
  endtask

  task automatic t_flags;
    run(36'hF_FFFF_FFFF, cw(0), 2'b10, "R12 pass ones", "R11 minus one");
    run(36'h0_0000_0000, cw(0), 2'b00, "R12 pass zero", "R10 zero");
    run(36'h0_8000_0000, cw(0), 2'b00, "R12 pass ovf", "R10 ovf32");
    run(36'h1_0000_0007, cw(0), 2'b11, "R12 pass odd", "R11 odd parity");
  endtask

  task automatic t_pipeline;
    logic [35:0] ops [4];
    logic [31:0] cws [4];
    logic [1:0]  kds [4];
    logic [43:0] e;
    ops[0] = 36'h0_0000_00FF; cws[0] = cw(4);  kds[0] = 2'b10;
    ops[1] = 36'h8_0000_0000; cws[1] = cw(2);  kds[1] = 2'b00;
    ops[2] = 36'hF_0000_00F0; cws[2] = cw(4);  kds[2] = 2'b01;
    ops[3] = 36'h0_1234_5678; cws[3] = cw(-8); kds[3] = 2'b11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        e = model(ops[i-2], cws[i-2], kds[i-2]);
        check("R1 back-to-back result", result_o, e[35:0]);
        check("R1 back-to-back flags", {28'b0, flags_o}, {28'b0, e[43:36]});
      end
      if (i < 4) begin
        operand_i = ops[i]; ctrl_i = cws[i]; kind_i = kds[i];
      end
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_err++;
    $display("FAIL R1 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    t_reset();
    t_right();
    t_logical_right();
    t_left();
    t_negative();
    t_ignored_bits();
    t_flags();
    t_pipeline();
    finish_run();
  end
endmodule